// File: doc/BRIEF.md
# Chained Interrupt Status Controller

This block gathers single-cycle event pulses from a bus-terminal core into two latched status words. Each status word has its own mask word, and the block drives one level-sensitive interrupt request to a host. Bit 0 of the second status word is a live summary of the first word: it reads 1 whenever the first word holds an unmasked pending event. A host that services the second word first can therefore tell whether the first word also needs attention.

The block also keeps an interrupt log. When a message completes in the same cycle as an unmasked event in the first word, the block writes the message's 16-bit tag into a 64-entry circular buffer. A filter selects whether valid messages, invalid messages, both or neither are logged. Crossing the buffer's midpoint and wrapping its end are themselves events in the second status word. Four user-defined event lines from a sequencing engine feed the second word as well.

A small register port gives access to the status, mask, filter and pointer registers and to the log buffer. Read data appears one cycle after the read strobe. Reading a status word clears it.

Top module: `irq_chain_ctrl`

## Requirements
- R1: An event pulse on `ev1_i[n]` sets status-1 bit n at the next clock edge whether or not mask-1 bit n is set; masks reset to 0.
- R2: `irq_o` is high exactly when some status bit is set in either word together with its mask bit; bit 0 of status-2 counts as a status bit, masked by mask-2 bit 0.
- R3: Status-2 bit 0 reads 1 while (status-1 AND mask-1) is nonzero and 0 otherwise; reading status-2 does not clear it.
- R4: A read returns the register value on `reg_rdata_o` with `reg_rvalid_o` high one cycle after `reg_rd_i`. A read of address 0 (status-1) or 2 (status-2) clears that word at the same edge, but an event arriving in the read cycle stays set.
- R5: Status-2 is laid out as follows: bits 4:1 take `user_irq_i[3:0]`, bit 5 is log wrap, bit 6 is log midpoint, and bits 15:7 take `ext2_i[8:0]`.
- R6: When `msg_done_i` is high in the same cycle as an unmasked event on `ev1_i`, and the filter admits the message, `msg_tag_i` is written to log entry `ptr` and `ptr` (address 4, bits 5:0) increments modulo 64. Log entry k reads at address 64+k. Without an unmasked event, nothing is written.
- R7: Filter register (address 5) bit 0 admits valid messages and bit 1 admits invalid ones (`msg_valid_i` = 0). It resets to 3.
- R8: A log write into entry 31 sets status-2 bit 6, and a log write into entry 63 sets status-2 bit 5.
- R9: After reset, both status words, both masks and the pointer are 0, the filter is 3 and `irq_o` is 0.
- R10: Writes to the status addresses 0 and 2 have no effect. The mask registers are at addresses 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev1_i | input | 16 | Event pulses into status-1 |
| ext2_i | input | 9 | Event pulses into status-2 bits 15:7 |
| user_irq_i | input | 4 | User-defined event pulses into status-2 bits 4:1 |
| msg_done_i | input | 1 | Message completion strobe |
| msg_valid_i | input | 1 | Completed message was valid |
| msg_tag_i | input | 16 | Tag logged for the completed message |
| reg_addr_i | input | 7 | Register address; bit 6 set selects a log entry |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, one cycle after the strobe |
| reg_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request to host |

## Verification
The embedded properties assume that `reg_rd_i` and `reg_wr_i` are never high in the same cycle and that every input changes only between clock edges. The stimulus issues at most one register operation per cycle. It drives all inputs on the falling edge and holds them for a full period. Events that race a clearing read are deliberately placed in the read cycle. Log writes are issued back to back so that the midpoint and wrap crossings happen on consecutive pointer values.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DW     = 16;
    localparam int AW     = 7;
    localparam int QDEPTH = 64;
    localparam int QAW    = $clog2(QDEPTH);
    localparam int NUSER  = 4;
    localparam int NEXT2  = 9;

    localparam int S2_USER_LO = 1;
    localparam int S2_WRAP    = S2_USER_LO + NUSER;
    localparam int S2_MID     = S2_WRAP + 1;
    localparam int S2_EXT_LO  = S2_MID + 1;

    typedef enum logic [AW-2:0] {
        RA_STAT1 = 6'd0,
        RA_MASK1 = 6'd1,
        RA_STAT2 = 6'd2,
        RA_MASK2 = 6'd3,
        RA_QPTR  = 6'd4,
        RA_QFILT = 6'd5
    } reg_sel_e;

    typedef struct packed {
        logic wrap;
        logic mid;
    } qevt_t;

    function automatic logic [DW-1:0] pack_stat2_ev(
        input logic [NUSER-1:0] user,
        input logic [NEXT2-1:0] ext,
        input qevt_t            qe
    );
        logic [DW-1:0] v;
        v = '0;
        v[S2_USER_LO +: NUSER] = user;
        v[S2_WRAP]             = qe.wrap;
        v[S2_MID]              = qe.mid;
        v[S2_EXT_LO +: NEXT2]  = ext;
        return v;
    endfunction

endpackage

// File: rtl/irq_stat_word.sv
module irq_stat_word #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev_i,
    input  logic         clr_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] mask_d_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);

    logic [W-1:0] stat_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (clr_i ? '0 : stat_q) | ev_i;
            if (mask_wr_i) mask_q <= mask_d_i;
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign pend_o = |(stat_q & mask_q);

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (ev_i != '0) |=> ((stat_q & $past(ev_i)) == $past(ev_i))); // R1

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && ev_i == '0) |=> (stat_q == '0)); // R4

endmodule

// File: rtl/irq_msg_log.sv
module irq_msg_log
    import irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           msg_done_i,
    input  logic           msg_valid_i,
    input  logic           msg_hit_i,
    input  logic [DW-1:0]  tag_i,
    input  logic           filt_wr_i,
    input  logic [1:0]     filt_d_i,
    input  logic [QAW-1:0] rd_idx_i,
    output logic [DW-1:0]  rd_data_o,
    output logic [QAW-1:0] ptr_o,
    output logic [1:0]     filt_o,
    output qevt_t          qevt_o
);

    logic [DW-1:0]  buf_q [QDEPTH];
    logic [QAW-1:0] ptr_q;
    logic [1:0]     filt_q;
    logic           admit, wr_en;

    assign admit = msg_valid_i ? filt_q[0] : filt_q[1];
    assign wr_en = msg_done_i && msg_hit_i && admit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            filt_q <= 2'b11;
        end else begin
            if (wr_en)     ptr_q  <= ptr_q + QAW'(1);
            if (filt_wr_i) filt_q <= filt_d_i;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) buf_q[ptr_q] <= tag_i;
    end

    assign qevt_o.wrap = wr_en && (ptr_q == QAW'(QDEPTH - 1));
    assign qevt_o.mid  = wr_en && (ptr_q == QAW'(QDEPTH/2 - 1));
    assign rd_data_o   = buf_q[rd_idx_i];
    assign ptr_o       = ptr_q;
    assign filt_o      = filt_q;

    AST_PTR_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ptr_q == $past(ptr_q) + QAW'(1))); // R6

    AST_FILTERED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (msg_done_i && !admit) |=> $stable(ptr_q)); // R7

    AST_CROSSING_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({qevt_o.wrap, qevt_o.mid})); // R8

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    ev1_i,
    input  logic [NEXT2-1:0] ext2_i,
    input  logic [NUSER-1:0] user_irq_i,
    input  logic             msg_done_i,
    input  logic             msg_valid_i,
    input  logic [DW-1:0]    msg_tag_i,
    input  logic [AW-1:0]    reg_addr_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [DW-1:0]    reg_wdata_i,
    output logic [DW-1:0]    reg_rdata_o,
    output logic             reg_rvalid_o,
    output logic             irq_o
);

    logic [DW-1:0]  stat1, mask1, stat2_raw, mask2, stat2_view, qdata, rd_mux;
    logic [DW-1:0]  ev2;
    logic [QAW-1:0] qptr;
    logic [1:0]     qfilt;
    logic           pend1, pend2_raw, is_q;
    qevt_t          qevt;
    reg_sel_e       sel;

    assign is_q = reg_addr_i[AW-1];
    assign sel  = reg_sel_e'(reg_addr_i[AW-2:0]);
    assign ev2  = pack_stat2_ev(user_irq_i, ext2_i, qevt);

    irq_stat_word #(.W(DW)) u_word1 (
        .clk(clk), .rst(rst), .ev_i(ev1_i),
        .clr_i(reg_rd_i && !is_q && sel == RA_STAT1),
        .mask_wr_i(reg_wr_i && !is_q && sel == RA_MASK1),
        .mask_d_i(reg_wdata_i),
        .stat_o(stat1), .mask_o(mask1), .pend_o(pend1)
    );

    irq_stat_word #(.W(DW)) u_word2 (
        .clk(clk), .rst(rst), .ev_i(ev2),
        .clr_i(reg_rd_i && !is_q && sel == RA_STAT2),
        .mask_wr_i(reg_wr_i && !is_q && sel == RA_MASK2),
        .mask_d_i(reg_wdata_i),
        .stat_o(stat2_raw), .mask_o(mask2), .pend_o(pend2_raw)
    );

    irq_msg_log u_log (
        .clk(clk), .rst(rst),
        .msg_done_i(msg_done_i), .msg_valid_i(msg_valid_i),
        .msg_hit_i(|(ev1_i & mask1)), .tag_i(msg_tag_i),
        .filt_wr_i(reg_wr_i && !is_q && sel == RA_QFILT),
        .filt_d_i(reg_wdata_i[1:0]),
        .rd_idx_i(reg_addr_i[QAW-1:0]), .rd_data_o(qdata),
        .ptr_o(qptr), .filt_o(qfilt), .qevt_o(qevt)
    );

    assign stat2_view = {stat2_raw[DW-1:1], pend1};
    assign irq_o      = pend2_raw | (pend1 & mask2[0]) | pend1;

    always_comb begin
        rd_mux = '0;
        if (is_q) rd_mux = qdata;
        else begin
            case (sel)
                RA_STAT1: rd_mux = stat1;
                RA_MASK1: rd_mux = mask1;
                RA_STAT2: rd_mux = stat2_view;
                RA_MASK2: rd_mux = mask2;
                RA_QPTR:  rd_mux = DW'(qptr);
                RA_QFILT: rd_mux = DW'(qfilt);
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata_o  <= '0;
            reg_rvalid_o <= 1'b0;
        end else begin
            reg_rvalid_o <= reg_rd_i;
            if (reg_rd_i) reg_rdata_o <= rd_mux;
        end
    end

    AST_STAT2_BIT0_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat2_raw[0] == 1'b0)); // R3

    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        reg_rd_i |=> reg_rvalid_o); // R4

endmodule

// File: tb/irq_chain_ctrl_tb_top.sv
module irq_chain_ctrl_tb_top;
    import irq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DW-1:0]    ev1_i = '0;
    logic [NEXT2-1:0] ext2_i = '0;
    logic [NUSER-1:0] user_irq_i = '0;
    logic             msg_done_i = 1'b0, msg_valid_i = 1'b0;
    logic [DW-1:0]    msg_tag_i = '0;
    logic [AW-1:0]    reg_addr_i = '0;
    logic             reg_wr_i = 1'b0, reg_rd_i = 1'b0;
    logic [DW-1:0]    reg_wdata_i = '0;
    logic [DW-1:0]    reg_rdata_o;
    logic             reg_rvalid_o, irq_o;

    int n_chk = 0, n_fail = 0, wp = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] msk_q[$];
    string         tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_chain_ctrl dut_i (.*);

    always @(negedge clk) begin
        if (!rst && reg_rvalid_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL unexpected read data %h expected none", reg_rdata_o);
            end else begin
                logic [DW-1:0] e, m;
                string t;
                e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
                if (m != '0) begin
                    n_chk++;
                    if ((reg_rdata_o & m) !== (e & m)) begin
                        n_fail++;
                        $display("FAIL %s read actual %h expected %h", t, reg_rdata_o, e);
                    end
                end
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        reg_addr_i = a; reg_rd_i = 1'b1;
        exp_q.push_back(e); msk_q.push_back(16'hFFFF); tag_q.push_back(t);
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic rd_drop(input logic [AW-1:0] a);
        reg_addr_i = a; reg_rd_i = 1'b1;
        exp_q.push_back('0); msk_q.push_back('0); tag_q.push_back("none");
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic pulse1(input logic [DW-1:0] v);
        ev1_i = v; @(negedge clk); ev1_i = '0;
    endtask

    task automatic msg(input logic v, input logic [DW-1:0] tag, input logic [DW-1:0] ev);
        msg_done_i = 1'b1; msg_valid_i = v; msg_tag_i = tag; ev1_i = ev;
        @(negedge clk);
        msg_done_i = 1'b0; ev1_i = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s irq actual %b expected %b", t, irq_o, e);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk_irq(1'b0, "R9");
        rd(7'd0, 16'h0000, "R9 stat1");
        rd(7'd1, 16'h0000, "R9 mask1");
        rd(7'd2, 16'h0000, "R9 stat2");
        rd(7'd3, 16'h0000, "R9 mask2");
        rd(7'd4, 16'h0000, "R9 ptr");
        rd(7'd5, 16'h0003, "R9 filter");
        // R1 masked event latches, no request
        pulse1(16'h0008);
        chk_irq(1'b0, "R1 masked");
        rd(7'd0, 16'h0008, "R1 latched");
        rd(7'd0, 16'h0000, "R4 cleared");
        // R2/R3 unmasked and chain
        wr(7'd1, 16'h0008);
        rd(7'd1, 16'h0008, "R10 mask1");
        pulse1(16'h0008);
        chk_irq(1'b1, "R2 unmasked");
        rd(7'd2, 16'h0001, "R3 chain set");
        chk_irq(1'b1, "R3 chain kept");
        rd(7'd0, 16'h0008, "R2 stat1");
        chk_irq(1'b0, "R2 after clear");
        rd(7'd2, 16'h0000, "R3 chain gone");
        // R4 event during clearing read
        pulse1(16'h0002);
        ev1_i = 16'h0020;
        rd(7'd0, 16'h0002, "R4 old value");
        ev1_i = '0;
        rd(7'd0, 16'h0020, "R4 race kept");
        // R5 user and external bits
        user_irq_i = 4'b1010; @(negedge clk); user_irq_i = '0;
        chk_irq(1'b0, "R5 user masked");
        wr(7'd3, 16'h0010);
        chk_irq(1'b1, "R5 user unmasked");
        rd(7'd2, 16'h0014, "R5 user bits");
        chk_irq(1'b0, "R5 cleared");
        ext2_i = 9'h001; @(negedge clk); ext2_i = '0;
        rd(7'd2, 16'h0080, "R5 ext bit");
        // R10 status writes ignored
        wr(7'd0, 16'hFFFF);
        wr(7'd2, 16'hFFFF);
        rd(7'd0, 16'h0000, "R10 stat1");
        rd(7'd2, 16'h0000, "R10 stat2");
        chk_irq(1'b0, "R10 irq");
        // R6 logging
        msg(1'b1, 16'hA001, 16'h0008); wp++;
        rd(7'd64, 16'hA001, "R6 entry0");
        rd(7'd4, 16'(wp), "R6 ptr step");
        msg(1'b1, 16'hA0FF, 16'h0004);
        rd(7'd4, 16'(wp), "R6 masked no log");
        rd_drop(7'd0);
        // R7 filter
        wr(7'd5, 16'h0001);
        msg(1'b0, 16'hB001, 16'h0008);
        rd(7'd4, 16'(wp), "R7 invalid dropped");
        msg(1'b1, 16'hB002, 16'h0008); wp++;
        rd(7'd4, 16'(wp), "R7 valid kept");
        rd(7'd65, 16'hB002, "R7 entry1");
        wr(7'd5, 16'h0002);
        msg(1'b1, 16'hB003, 16'h0008);
        rd(7'd4, 16'(wp), "R7 valid dropped");
        msg(1'b0, 16'hB004, 16'h0008); wp++;
        rd(7'd4, 16'(wp), "R7 invalid kept");
        wr(7'd5, 16'h0000);
        msg(1'b1, 16'hB005, 16'h0008);
        msg(1'b0, 16'hB006, 16'h0008);
        rd(7'd4, 16'(wp), "R7 none kept");
        wr(7'd5, 16'h0003);
        rd_drop(7'd0);
        rd_drop(7'd2);
        // R8 midpoint and wrap
        while (wp < 32) begin msg(1'b1, 16'(16'h2000 + wp), 16'h0008); wp++; end
        rd_drop(7'd0);
        rd(7'd2, 16'h0040, "R8 midpoint");
        rd(7'd4, 16'd32, "R8 ptr 32");
        while (wp < 64) begin msg(1'b1, 16'(16'h2000 + wp), 16'h0008); wp++; end
        rd_drop(7'd0);
        rd(7'd2, 16'h0020, "R8 wrap");
        rd(7'd4, 16'd0, "R6 ptr wrapped");
        rd(7'd127, 16'h203F, "R6 entry63");
        rd(7'd95, 16'h201F, "R6 entry31");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule